// File: doc/BRIEF.md
# Manchester Lighting-Bus Frame Receiver

This block decodes frames arriving on a single-wire, two-phase (Manchester) lighting control bus. The line is brought into the clock domain through a two-flop synchroniser and optionally inverted by a polarity input. The receiver then finds bit boundaries with nothing more than an edge detector and a half-bit timer whose length in clock cycles comes from a port. Every bit is carried as two equal half-bit phases. The receiver keeps the level of the first phase and takes the bit value from the second.

A frame ends when both phases of a bit slot are at the rest level, which is a pattern a data bit can never produce. At that point the number of collected bits (the start bit included) is checked. Nine bits give a short frame carrying one byte. Seventeen bits give a long frame carrying two bytes. Any other count is thrown away silently. Accepted payloads appear on the byte outputs together with a one-cycle strobe and a short/long flag. The receiver returns to its rest state after every frame end, good or bad.

Top module: `lbus_frame_rx`

## Requirements
- R1: While rst_n is low at a rising clock edge, the next cycle shows frame_valid = 0, frame_long = 0, byte0 = 0 and byte1 = 0.
- R2: With pol_high = 0 the decoded level equals line_in. With pol_high = 1 it is the inverse of line_in. The decoded rest level is 1, so the line rests high for pol_high = 0 and low for pol_high = 1.
- R3: At rest, a change of the decoded level opens a frame, and the half-bit that follows that change is the first phase of the start bit.
- R4: Inside a frame a sample is taken at every decoded-level change. Without a change, a sample is forced h + floor(h/2) cycles after the last timing reference (h = half_len, h >= 4), and the reference is then moved floor(h/2) cycles back. A change arriving on the cycle the forced sample falls due yields a single sample that re-times from the change.
- R5: A bit of value b is carried as decoded phases (not b, b), and the start bit has value 1. Samples alternate between first and second phase, and each pair commits the second-phase level as one bit. A pair whose phases are both 1 is a frame end and is not a bit.
- R6: A frame end after exactly 9 bits gives byte0 = bits 1..8 (bit 1 is the most significant bit), byte1 = 0 and frame_long = 0.
- R7: A frame end after exactly 17 bits gives byte0 = bits 1..8 and byte1 = bits 9..16 (each MSB first) with frame_long = 1.
- R8: A frame end after any other bit count produces no strobe and leaves frame_long, byte0 and byte1 unchanged. The byte outputs change only in a cycle in which frame_valid is high.
- R9: After every frame end the bit buffer is emptied and the receiver rests. A new frame may open as early as the cycle after the frame end and is decoded in full.
- R10: frame_valid is high for exactly one cycle. If P is the first rising edge at which line_in shows the opening change of an N-bit accepted frame sent with exact half-bits and left at rest afterwards, the strobe is high in the cycle after edge P + (2N+2)·h + floor(h/2) + 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_in | input | 1 | Raw bus line, asynchronous to clk |
| pol_high | input | 1 | 1 selects inverted line sense; change only during reset |
| half_len | input | HALF_W | Half-bit length h in clock cycles; change only at rest |
| frame_valid | output | 1 | One-cycle strobe for an accepted frame |
| frame_long | output | 1 | 1 when the last accepted frame had 17 bits |
| byte0 | output | 8 | First payload byte |
| byte1 | output | 8 | Second payload byte, 0 after a short frame |

## Verification
Two things can land on the same cycle: a line edge and the forced sample of the half-bit timer. The bench provokes this by stretching one half-bit of the start bit to exactly 1.5 half-bits, so that the following edge arrives on the cycle the timeout falls due. It then judges the result by the payload and by the strobe cycle, which must move later by floor(h/2) with one sample taken rather than two. A second collision comes from starting a frame the cycle after the previous frame end. Its opening edge coincides with the loading of the previous payload, and both frames must come out intact.

// File: rtl/lbus_frame_rx.sv
module lbus_frame_rx #(
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_in,
  input  logic              pol_high,
  input  logic [HALF_W-1:0] half_len,
  output logic              frame_valid,
  output logic              frame_long,
  output logic [7:0]        byte0,
  output logic [7:0]        byte1
);
  localparam int CNT_W = HALF_W + 1;
  localparam int NB_W  = 5;
  localparam logic [NB_W-1:0] SHORT_LEN = NB_W'(9);
  localparam logic [NB_W-1:0] LONG_LEN  = NB_W'(17);
  localparam logic [NB_W-1:0] NB_MAX    = '1;

  typedef enum logic [1:0] {S_REST, S_PH0, S_PH1} st_t;

  st_t              st;
  logic             s1, s2, prev, ph0_lvl, done_q, done_long;
  logic [CNT_W-1:0] cnt;
  logic [NB_W-1:0]  nb;
  logic [15:0]      sr;

  logic             lvl, chg, busy, tmo, samp, len_ok;
  logic [CNT_W-1:0] limit, backdate;

  assign lvl      = pol_high ? ~s2 : s2;
  assign chg      = lvl ^ prev;
  assign busy     = (st != S_REST);
  assign limit    = CNT_W'(half_len) + CNT_W'(half_len >> 1);
  assign backdate = CNT_W'(half_len >> 1) + CNT_W'(1);
  assign tmo      = (cnt == limit);
  assign samp     = busy && (chg || tmo);
  assign len_ok   = (nb == SHORT_LEN) || (nb == LONG_LEN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1          <= ~pol_high;
      s2          <= ~pol_high;
      prev        <= 1'b1;
      st          <= S_REST;
      cnt         <= '0;
      nb          <= '0;
      sr          <= '0;
      ph0_lvl     <= 1'b0;
      done_q      <= 1'b0;
      done_long   <= 1'b0;
      frame_valid <= 1'b0;
      frame_long  <= 1'b0;
      byte0       <= '0;
      byte1       <= '0;
    end else begin
      s1          <= line_in;
      s2          <= s1;
      prev        <= lvl;
      frame_valid <= done_q;
      done_q      <= 1'b0;

      if (done_q) begin
        frame_long <= done_long;
        byte0      <= done_long ? sr[15:8] : sr[7:0];
        byte1      <= done_long ? sr[7:0]  : 8'h00;
      end

      if (!busy) begin
        if (chg) begin
          st  <= S_PH0;
          cnt <= CNT_W'(1);
          nb  <= '0;
          sr  <= '0;
        end
      end else if (samp) begin
        cnt <= chg ? CNT_W'(1) : backdate;
        if (st == S_PH0) begin
          ph0_lvl <= prev;
          st      <= S_PH1;
        end else if (ph0_lvl && prev) begin
          st        <= S_REST;
          done_q    <= len_ok;
          done_long <= (nb == LONG_LEN);
          nb        <= '0;
        end else begin
          sr <= {sr[14:0], prev};
          nb <= (nb == NB_MAX) ? nb : nb + NB_W'(1);
          st <= S_PH0;
        end
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/lbus_frame_rx_chk.sv
module lbus_frame_rx_chk #(
  parameter int HALF_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_valid,
  input logic              frame_long,
  input logic [7:0]        byte0,
  input logic [7:0]        byte1,
  input logic [HALF_W-1:0] half_len,
  input logic              busy,
  input logic [HALF_W:0]   cnt
);
  logic [HALF_W:0] bound;
  assign bound = {1'b0, half_len} + {2'b00, half_len[HALF_W-1:1]};

  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (!frame_valid && !frame_long && byte0 == 8'h00 && byte1 == 8'h00));

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);

  a_r8_bytes_move_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(byte0) || !$stable(byte1) || !$stable(frame_long)) |-> frame_valid);

  a_r6_short_clears_second: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && !frame_long) |-> byte1 == 8'h00);

  a_r4_timer_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt != '0 && cnt <= bound));
endmodule

bind lbus_frame_rx lbus_frame_rx_chk #(.HALF_W(HALF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame_long(frame_long),
  .byte0(byte0), .byte1(byte1), .half_len(half_len), .busy(busy), .cnt(cnt)
);

// File: tb/lbus_frame_rx_test.sv
module lbus_frame_rx_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_in = 1'b1;
  logic        pol_high = 1'b0;
  logic [15:0] half_len;
  logic        frame_valid, frame_long;
  logic [7:0]  byte0, byte1;

  int hl = 8;
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit model_on = 1'b0;
  bit finished = 1'b0;

  int         exp_cyc[$];
  logic [16:0] exp_dat[$];
  logic        h_long = 1'b0;
  logic [7:0]  h_b0 = 8'h00, h_b1 = 8'h00;

  assign half_len = hl[15:0];

  lbus_frame_rx uut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .pol_high(pol_high),
    .half_len(half_len), .frame_valid(frame_valid), .frame_long(frame_long),
    .byte0(byte0), .byte1(byte1)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Reference model: expected strobe cycles and payloads, held outputs between frames.
  always @(negedge clk) begin
    if (rst_n && model_on) begin
      logic  ev;
      string tag;
      ev = 1'b0;
      if (exp_cyc.size() > 0 && exp_cyc[0] == cyc) begin
        ev     = 1'b1;
        h_long = exp_dat[0][16];
        h_b0   = exp_dat[0][15:8];
        h_b1   = exp_dat[0][7:0];
        void'(exp_cyc.pop_front());
        void'(exp_dat.pop_front());
      end
      chk("R10 strobe", int'(frame_valid), int'(ev));
      if (!ev)        tag = "R8 hold";
      else if (h_long) tag = "R7 long";
      else             tag = "R6 short";
      chk({tag, " flag"},  int'(frame_long), int'(h_long));
      chk({tag, " byte0"}, int'(byte0), int'(h_b0));
      chk({tag, " byte1"}, int'(byte1), int'(h_b1));
    end
  end

  // Called at a negedge; drives n bits as decoded phases, then rests for gap cycles.
  task automatic send(input int n, input logic [7:0] b0, input logic [7:0] b1,
                      input int stretch, input int gap);
    int   c0;
    int   extra;
    logic bitv, lv;
    c0    = cyc;
    extra = (stretch >= 0) ? hl / 2 : 0;
    if (n == 9 || n == 17) begin
      exp_cyc.push_back(c0 + 4 + (2*n + 2)*hl + hl/2 + extra);
      exp_dat.push_back({(n == 17), b0, (n == 17) ? b1 : 8'h00});
    end
    for (int j = 0; j < n; j++) begin
      if (j == 0)       bitv = 1'b1;
      else if (j <= 8)  bitv = b0[8-j];
      else if (j <= 16) bitv = b1[16-j];
      else              bitv = j[0];
      for (int p = 0; p < 2; p++) begin
        lv = (p == 0) ? ~bitv : bitv;
        line_in = pol_high ? ~lv : lv;
        repeat ((2*j + p == stretch) ? hl + hl/2 : hl) @(negedge clk);
      end
    end
    line_in = pol_high ? 1'b0 : 1'b1;
    repeat (gap) @(negedge clk);
  endtask

  function automatic int rest_gap();
    return 3*hl + 12;
  endfunction

  task automatic reset_checks();
    chk("R1 strobe", int'(frame_valid), 0);
    chk("R1 flag",   int'(frame_long), 0);
    chk("R1 byte0",  int'(byte0), 0);
    chk("R1 byte1",  int'(byte1), 0);
  endtask

  task automatic do_reset(input logic pol);
    @(negedge clk);
    model_on = 1'b0;
    rst_n    = 1'b0;
    pol_high = pol;
    line_in  = pol ? 1'b0 : 1'b1;
    exp_cyc.delete();
    exp_dat.delete();
    h_long = 1'b0; h_b0 = 8'h00; h_b1 = 8'h00;
    repeat (4) @(negedge clk);
    reset_checks();
    rst_n    = 1'b1;
    model_on = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    do_reset(1'b0);

    send(9,  8'hA5, 8'h00, -1, rest_gap());   // R6, R3, R5
    send(17, 8'h3C, 8'h81, -1, rest_gap());   // R7
    send(9,  8'h00, 8'h00, -1, rest_gap());   // R6 all zeros
    send(9,  8'hFF, 8'h00, -1, rest_gap());   // R6 all ones
    send(17, 8'hFF, 8'h00, -1, rest_gap());   // R7

    send(8,  8'h12, 8'h00, -1, rest_gap());   // R8 too short
    send(10, 8'h34, 8'h00, -1, rest_gap());   // R8
    send(16, 8'h56, 8'h78, -1, rest_gap());   // R8
    send(18, 8'h9A, 8'hBC, -1, rest_gap());   // R8 too long
    send(1,  8'h00, 8'h00, -1, rest_gap());   // R8 start bit only
    send(9,  8'h5A, 8'h00, -1, rest_gap());   // R9 recovery after bad frames

    send(17, 8'hC3, 8'h96, 1, rest_gap());    // R4 edge meets timeout

    send(9,  8'h81, 8'h00, -1, 2*hl + hl/2 + 1);  // R9 next frame right after end
    send(17, 8'h7E, 8'h24, -1, rest_gap());

    hl = 5;                                   // R4 odd half-bit length
    repeat (4) @(negedge clk);
    send(9,  8'h96, 8'h00, -1, rest_gap());
    send(17, 8'h12, 8'h34, -1, rest_gap());
    send(11, 8'h44, 8'h00, -1, rest_gap());   // R8

    hl = 8;
    do_reset(1'b1);                           // R2 inverted sense, R1 again
    send(9,  8'h69, 8'h00, -1, rest_gap());
    send(17, 8'hE7, 8'h18, -1, rest_gap());
    send(12, 8'h0F, 8'h00, -1, rest_gap());   // R8
    send(9,  8'hB2, 8'h00, -1, rest_gap());

    repeat (20) @(negedge clk);
    chk("R10 pending strobes", exp_cyc.size(), 0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule